// File: doc/BRIEF.md
# Configurable Sampled Input Filter

This block conditions one asynchronous digital input before a timer uses it. The input is first brought into the local clock domain by a short synchronizer chain. It is then sampled on strobes that a prescaler derives from one of two clock enables: the timer kernel enable or the base sampling enable. The filtered output moves to a new level only after that level has been seen on a required number of consecutive sampling strobes.

A 4-bit selector picks two things at once from a fixed table: the sampling rate and the number of consecutive equal samples required. Three codes sample on every kernel enable. Twelve codes sample on the base enable divided by 2, 4, 8, 16 or 32. Code 0 applies no filtering and copies the synchronized input on every base enable. Writing a new selector value restarts both the prescaler and the run of equal samples. The filtered output keeps its current level across the change.

Top module: `sampled_input_filter`

## Requirements
- R1: After reset the filtered output, the prescaler and the run counter are all 0.
- R2: With selector code 0 (0000), each base enable takes one sample and copies it to the output, so the output follows the synchronized input whenever the base enable is high.
- R3: Codes 1, 2 and 3 sample on every kernel enable and require 2, 4 and 8 consecutive equal samples respectively. The base enable has no effect in these codes.
- R4: Codes 4 to 15 sample on the base enable divided by a fixed factor and require a fixed count: codes 4 and 5 divide by 2 with counts 6 and 8; codes 6 and 7 divide by 4 with counts 6 and 8; codes 8 and 9 divide by 8 with counts 6 and 8; codes 10, 11 and 12 divide by 16 with counts 5, 6 and 8; codes 13, 14 and 15 divide by 32 with counts 5, 6 and 8. The kernel enable has no effect in these codes.
- R5: The output takes a new level only when that level has appeared on the required number of consecutive samples. A sample that differs from the previous one restarts the count at 1, so a shorter pulse never reaches the output.
- R6: The output changes only in the cycle after a sampling strobe.
- R7: A selector value that differs from the previous cycle's value clears the prescaler and the run counter, and produces no sample in that cycle. The output level is kept.
- R8: A change on the raw input reaches the sampler through two register stages, so with code 0 and the base enable held high, the output changes on the third clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kern_en_i | input | 1 | Kernel-rate clock enable |
| base_en_i | input | 1 | Base sampling clock enable |
| sel_i | input | 4 | Filter selector code |
| din_i | input | 1 | Raw asynchronous input |
| dout_o | output | 1 | Filtered output |

## Verification
The hardest case to reach is a selector change that lands in the middle of a run. If the counter were not cleared, the old partial run would make the output flip too early under the new, shorter count. The stimulus reaches this case directly: it builds four equal samples under a count of 8, then switches to a count of 4 and checks that the output still holds two samples later. Long random phases cover the /32 codes. In these phases the base enable stays high and the input toggles rarely, so runs of 8 samples at the slowest rate actually complete.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int CODE_W = 4;
  localparam int DLOG_W = 3;
  localparam int RUN_W  = 4;
  localparam int MAX_DIV_LOG = 5;
  localparam int PRE_W  = MAX_DIV_LOG;

  typedef struct packed {
    logic              use_kern;
    logic [DLOG_W-1:0] div_log2;
    logic [RUN_W-1:0]  need;
  } sif_cfg_t;

  function automatic sif_cfg_t sif_decode(input logic [CODE_W-1:0] code);
    sif_cfg_t c;
    c.use_kern = 1'b0;
    c.div_log2 = '0;
    c.need     = RUN_W'(1);
    case (code)
      4'd0:  begin c.use_kern = 1'b0; c.div_log2 = 3'd0; c.need = 4'd1; end
      4'd1:  begin c.use_kern = 1'b1; c.div_log2 = 3'd0; c.need = 4'd2; end
      4'd2:  begin c.use_kern = 1'b1; c.div_log2 = 3'd0; c.need = 4'd4; end
      4'd3:  begin c.use_kern = 1'b1; c.div_log2 = 3'd0; c.need = 4'd8; end
      4'd4:  begin c.div_log2 = 3'd1; c.need = 4'd6; end
      4'd5:  begin c.div_log2 = 3'd1; c.need = 4'd8; end
      4'd6:  begin c.div_log2 = 3'd2; c.need = 4'd6; end
      4'd7:  begin c.div_log2 = 3'd2; c.need = 4'd8; end
      4'd8:  begin c.div_log2 = 3'd3; c.need = 4'd6; end
      4'd9:  begin c.div_log2 = 3'd3; c.need = 4'd8; end
      4'd10: begin c.div_log2 = 3'd4; c.need = 4'd5; end
      4'd11: begin c.div_log2 = 3'd4; c.need = 4'd6; end
      4'd12: begin c.div_log2 = 3'd4; c.need = 4'd8; end
      4'd13: begin c.div_log2 = 3'd5; c.need = 4'd5; end
      4'd14: begin c.div_log2 = 3'd5; c.need = 4'd6; end
      default: begin c.div_log2 = 3'd5; c.need = 4'd8; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else if (i == 0) stg_q[i] <= d_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sif_prescale.sv
module sif_prescale
  import sif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DLOG_W-1:0] div_log2_i,
  output logic              stb_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;

  // terminal count = divide factor - 1
  always_comb begin
    for (int i = 0; i < PRE_W; i++) term[i] = (i < int'(div_log2_i));
  end

  assign stb_o = en_i && !clr_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= stb_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sif_runlen.sv
module sif_runlen
  import sif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             smp_i,
  input  logic [RUN_W-1:0] need_i,
  output logic [RUN_W-1:0] run_o,
  output logic             q_o
);
  logic [RUN_W-1:0] run_q, run_nx;
  logic             last_q, q_q;
  logic             same;

  assign same   = (run_q != '0) && (smp_i == last_q);
  // saturate at the required count
  assign run_nx = !same ? RUN_W'(1) : ((run_q >= need_i) ? run_q : run_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      last_q <= 1'b0;
      q_q    <= 1'b0;
    end else if (clr_i) begin
      run_q  <= '0;
    end else if (stb_i) begin
      run_q  <= run_nx;
      last_q <= smp_i;
      if (run_nx >= need_i) q_q <= smp_i;
    end
  end

  assign run_o = run_q;
  assign q_o   = q_q;
endmodule

// File: rtl/sampled_input_filter.sv
module sampled_input_filter
  import sif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kern_en_i,
  input  logic              base_en_i,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              din_i,
  output logic              dout_o
);
  logic              din_sync;
  logic [CODE_W-1:0] sel_q;
  logic              sel_chg;
  sif_cfg_t          cfg;
  logic              src_en;
  logic              smp_stb;
  logic [RUN_W-1:0]  run_cnt;

  sif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (din_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  assign sel_chg = (sel_i != sel_q);
  assign cfg     = sif_decode(sel_i);
  assign src_en  = cfg.use_kern ? kern_en_i : base_en_i;

  sif_prescale u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_chg),
    .en_i      (src_en),
    .div_log2_i(cfg.div_log2),
    .stb_o     (smp_stb)
  );

  sif_runlen u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sel_chg),
    .stb_i (smp_stb),
    .smp_i (din_sync),
    .need_i(cfg.need),
    .run_o (run_cnt),
    .q_o   (dout_o)
  );
endmodule

// File: rtl/sif_checker.sv
module sif_checker
  import sif_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             base_en_i,
  input logic             use_kern,
  input logic             din_i,
  input logic             din_sync,
  input logic             sel_chg,
  input logic             smp_stb,
  input logic [RUN_W-1:0] run_cnt,
  input logic [RUN_W-1:0] need,
  input logic             dout_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 1'b1;
  end

  assert_out_on_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> $past(smp_stb));

  assert_out_is_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> (dout_o == $past(din_sync)));

  assert_run_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_chg |-> (run_cnt <= need));

  assert_clear_on_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> (run_cnt == '0));

  assert_no_strobe_on_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |-> !smp_stb);

  assert_base_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb && !use_kern) |-> base_en_i);

  assert_sync_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (din_sync == $past(din_i, 2)));
endmodule

bind sampled_input_filter sif_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .base_en_i(base_en_i),
  .use_kern (cfg.use_kern),
  .din_i    (din_i),
  .din_sync (din_sync),
  .sel_chg  (sel_chg),
  .smp_stb  (smp_stb),
  .run_cnt  (run_cnt),
  .need     (cfg.need),
  .dout_o   (dout_o)
);

// File: tb/sampled_input_filter_tb.sv
module sampled_input_filter_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       kern_en = 1'b0, base_en = 1'b0, din = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       dout;

  always #4 clk = ~clk;

  sampled_input_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .kern_en_i(kern_en), .base_en_i(base_en),
    .sel_i(sel), .din_i(din), .dout_o(dout)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  function automatic bit b_kern(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd3);
  endfunction
  function automatic int b_div(input logic [3:0] c);
    if (c <= 4'd3) return 1;
    if (c <= 4'd5) return 2;
    if (c <= 4'd7) return 4;
    if (c <= 4'd9) return 8;
    if (c <= 4'd12) return 16;
    return 32;
  endfunction
  function automatic int b_n(input logic [3:0] c);
    case (c)
      4'd0: return 1;  4'd1: return 2;  4'd2: return 4;  4'd3: return 8;
      4'd10, 4'd13: return 5;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: return 6;
      default: return 8;
    endcase
  endfunction
  function automatic string tag_of(input logic [3:0] c);
    if (c == 4'd0) return "R2";
    if (b_kern(c)) return "R3";
    return "R4";
  endfunction

  // reference: output = sample when the last n samples since the last clear agree
  bit md1, md2, m_out, smp;
  logic [3:0] psel;
  logic [7:0] hist;
  int ecnt, hn;
  always @(posedge clk) begin
    if (!rst_n) begin
      md1 = 0; md2 = 0; m_out = 0; psel = 0; hist = 0; ecnt = 0; hn = 0;
    end else begin
      smp = md2; md2 = md1; md1 = din;
      if (sel != psel) begin
        psel = sel; ecnt = 0; hn = 0;
      end else if (b_kern(sel) ? kern_en : base_en) begin
        ecnt++;
        if (ecnt == b_div(sel)) begin
          bit agree;
          ecnt = 0;
          hist = {hist[6:0], smp};
          if (hn < 8) hn++;
          agree = (hn >= b_n(sel));
          for (int i = 0; i < b_n(sel); i++) if (hist[i] != hist[0]) agree = 0;
          if (agree) m_out = smp;
        end
      end
    end
  end

  task automatic chk(input bit exp, input string t);
    n_chk++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", t, dout, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(m_out, tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_F17));
    repeat (3) @(negedge clk);
    chk(1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1");

    // R8 / R2: code 0, latency of three edges
    sel = 4'd0; base_en = 1'b1; tag = "R2";
    ticks(5);
    din = 1'b1;
    tick(); chk(1'b0, "R8");
    tick(); chk(1'b0, "R8");
    tick(); chk(1'b1, "R2");

    // R5: one-sample glitch under N=2 is rejected
    sel = 4'd1; kern_en = 1'b1; base_en = 1'b0; tag = "R5";
    ticks(10); chk(1'b1, "R5");
    din = 1'b0; tick(); din = 1'b1;
    ticks(6); chk(1'b1, "R5");

    // R3: base enable ignored in kernel codes
    kern_en = 1'b0; base_en = 1'b1; din = 1'b0; tag = "R3";
    ticks(20); chk(1'b1, "R3");

    // R4 / R6: kernel enable ignored, no strobe -> no change
    sel = 4'd15; kern_en = 1'b1; base_en = 1'b0; tag = "R4";
    ticks(300); chk(1'b1, "R4"); chk(1'b1, "R6");

    // R7: partial run is dropped on selector change
    sel = 4'd3; kern_en = 1'b1; base_en = 1'b0; din = 1'b1; tag = "R7";
    ticks(20); chk(1'b1, "R7");
    din = 1'b0; ticks(6);
    sel = 4'd2; ticks(3); chk(1'b1, "R7");
    ticks(3); chk(1'b0, "R7");

    // random phases, every code at least once
    for (int ph = 0; ph < 48; ph++) begin
      int pk;
      sel = (ph < 16) ? 4'(ph) : 4'($urandom % 16);
      tag = tag_of(sel);
      pk = $urandom % 4;
      for (int c = 0; c < 1500; c++) begin
        kern_en = ($urandom % 4) != 0;
        base_en = (pk == 3) ? 1'b1 : (($urandom % 3) == 0);
        if (($urandom % ((pk == 3) ? 400 : (2 << (pk * 2)))) == 0) din = ~din;
        tick();
      end
    end
    finish_run();
  end
endmodule